// File: doc/BRIEF.md
# Random Address-Pair Memory Tester

This block is a built-in self-test sequencer for a word-addressed memory whose words are split into a left half and a right half. A run starts on a one-cycle `start` pulse. The controller first pulses a reset toward the memory under test. It then repeats a fixed number of iterations. In each iteration it draws two different random addresses and four random data words from a 16-bit linear feedback shift register. It writes both halves of both addresses, then reads all four back one at a time and compares each one against the value it wrote.

The left half may carry bits that the memory does not store. For that reason, every left-half value is masked when it is drawn and again when it is compared. Using two distinct locations per iteration lets the test catch a write to one address that disturbs another. On the first mismatch the run stops. The controller then reports which of the four checks failed. The generator seed can be loaded between runs. Otherwise the generator carries on from where the previous run left it.

Top module: `pairmem_tester`

## Requirements
- R1: After reset, `done`, `busy`, `fail`, `uut_rst` and `mem_en` are all 0, and they stay 0 until `start` is pulsed.
- R2: A `seed_load` pulse while `busy` is 0 loads `seed_in` into the generator, and a zero seed is replaced by 1. A `seed_load` pulse while `busy` is 1 has no effect on the generated sequence.
- R3: A start that is accepted produces exactly one `uut_rst` pulse, one cycle long, before the first memory access of the run.
- R4: Each draw takes the current generator state S and then advances it to (S >> 1) XOR (S[0] ? 16'hB400 : 0). An iteration draws, in this order: addr1 (the low ADDR_W bits), addr2 (the low ADDR_W bits, redrawn until it differs from addr1), left1 (AND LEFT_MASK), right1, left2 (AND LEFT_MASK), right2.
- R5: Each iteration writes four times, one per cycle, in this order: addr1 left, addr1 right, addr2 left, addr2 right. `mem_half` = 0 selects the left half and 1 selects the right half.
- R6: After the writes, the four locations are read back in the same order. Each read is issued alone and its `mem_rdata` is sampled one cycle later. A left read is compared only on the LEFT_MASK bits, and a right read is compared on all bits.
- R7: On the first mismatch the run stops with `done`=1 and `fail`=1. `fail_code` is set to 0 for addr1 left, 1 for addr1 right, 2 for addr2 left and 3 for addr2 right, and no further access is made.
- R8: A run with no mismatch makes exactly 4×ITERATIONS writes and 4×ITERATIONS reads and then ends with `done`=1 and `fail`=0. Memory accesses occur only while `busy` is 1.
- R9: `done`, `fail` and `fail_code` hold until the next `start`. A restart without a seed load continues from the generator state left by the previous run.
- R10: The two addresses written in an iteration always differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted while not busy) |
| seed_load | input | 1 | Load generator seed (accepted while not busy) |
| seed_in | input | DATA_W | Seed value |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Run ended on a mismatch |
| fail_code | output | 2 | Which check failed |
| uut_rst | output | 1 | One-cycle reset pulse to the memory under test |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | 0 = left half, 1 = right half |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The bench builds the tester with ADDR_W=4, ITERATIONS=5 and LEFT_MASK=16'h0FFF. With only 16 words, the second address often collides with the first and has to be redrawn, so that path is exercised many times. Five iterations keep each run short enough to drive a mismatch into every one of the four checks, to stop a run in its second iteration, and to restart without reseeding. The narrow left mask leaves room for the memory model to return junk in the unmasked upper bits of left reads, which a correct run must ignore.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_A1,
        S_A2,
        S_L1,
        S_R1,
        S_L2,
        S_R2,
        S_WR,
        S_RD,
        S_CK,
        S_DONE
    } pmt_state_e;

    localparam logic HALF_LEFT  = 1'b0;
    localparam logic HALF_RIGHT = 1'b1;

endpackage

// File: rtl/pmt_lfsr.sv
module pmt_lfsr #(
    parameter int               WIDTH      = 16,
    parameter logic [WIDTH-1:0] TAPS       = 16'hB400,
    parameter logic [WIDTH-1:0] RESET_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             advance,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] SAFE_SEED =
        (RESET_SEED == '0) ? WIDTH'(1) : RESET_SEED;

    logic [WIDTH-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (load_val == '0) ? WIDTH'(1) : load_val;
        end else if (advance) begin
            state_d = (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SAFE_SEED;
        else        state_q <= state_d;
    end

    assign value = state_q;

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/pmt_operand_sel.sv
module pmt_operand_sel #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic [1:0]        step,
    input  logic [ADDR_W-1:0] addr1,
    input  logic [ADDR_W-1:0] addr2,
    input  logic [DATA_W-1:0] left1,
    input  logic [DATA_W-1:0] right1,
    input  logic [DATA_W-1:0] left2,
    input  logic [DATA_W-1:0] right2,
    output logic [ADDR_W-1:0] addr,
    output logic              half,
    output logic [DATA_W-1:0] data
);

    always_comb begin
        addr = step[1] ? addr2 : addr1;
        half = step[0];
        unique case (step)
            2'd0:    data = left1;
            2'd1:    data = right1;
            2'd2:    data = left2;
            default: data = right2;
        endcase
    end

endmodule

// File: rtl/pmt_compare.sv
module pmt_compare #(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] LEFT_MASK = 16'h3FFF
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    input  logic              half,
    output logic              mismatch
);

    logic [DATA_W-1:0] care;

    always_comb begin
        care     = (half == pmt_pkg::HALF_LEFT) ? LEFT_MASK : '1;
        mismatch = ((rdata ^ expected) & care) != '0;
    end

endmodule

// File: rtl/pairmem_tester.sv
module pairmem_tester #(
    parameter int                ADDR_W     = 10,
    parameter int                DATA_W     = 16,
    parameter int                ITERATIONS = 4096,
    parameter logic [DATA_W-1:0] LEFT_MASK  = 16'h3FFF,
    parameter logic [DATA_W-1:0] LFSR_TAPS  = 16'hB400,
    parameter logic [DATA_W-1:0] RESET_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seed_load,
    input  logic [DATA_W-1:0] seed_in,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [1:0]        fail_code,
    output logic              uut_rst,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_half,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    import pmt_pkg::*;

    localparam int                ITER_W    = $clog2(ITERATIONS + 1);
    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(ITERATIONS - 1);

    typedef struct packed {
        pmt_state_e        st;
        logic [1:0]        step;
        logic [ADDR_W-1:0] a1;
        logic [ADDR_W-1:0] a2;
        logic [DATA_W-1:0] l1;
        logic [DATA_W-1:0] r1;
        logic [DATA_W-1:0] l2;
        logic [DATA_W-1:0] r2;
        logic [ITER_W-1:0] iter;
        logic              fail;
        logic [1:0]        code;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DATA_W-1:0] draw;
    logic [ADDR_W-1:0] draw_addr;
    logic              drawing;
    logic              mismatch;
    logic [ADDR_W-1:0] op_addr;
    logic              op_half;
    logic [DATA_W-1:0] op_data;

    assign draw_addr = draw[ADDR_W-1:0];
    assign drawing   = (c_q.st == S_A1) || (c_q.st == S_A2) || (c_q.st == S_L1) ||
                       (c_q.st == S_R1) || (c_q.st == S_L2) || (c_q.st == S_R2);
    assign busy      = (c_q.st != S_IDLE) && (c_q.st != S_DONE);

    pmt_lfsr #(
        .WIDTH     (DATA_W),
        .TAPS      (LFSR_TAPS),
        .RESET_SEED(RESET_SEED)
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load && !busy),
        .load_val(seed_in),
        .advance (drawing),
        .value   (draw)
    );

    pmt_operand_sel #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) sel_i (
        .step  (c_q.step),
        .addr1 (c_q.a1),
        .addr2 (c_q.a2),
        .left1 (c_q.l1),
        .right1(c_q.r1),
        .left2 (c_q.l2),
        .right2(c_q.r2),
        .addr  (op_addr),
        .half  (op_half),
        .data  (op_data)
    );

    pmt_compare #(
        .DATA_W   (DATA_W),
        .LEFT_MASK(LEFT_MASK)
    ) cmp_i (
        .rdata   (mem_rdata),
        .expected(op_data),
        .half    (op_half),
        .mismatch(mismatch)
    );

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            S_IDLE, S_DONE: begin
                if (start) begin
                    c_d.st   = S_RST;
                    c_d.fail = 1'b0;
                    c_d.code = 2'd0;
                    c_d.iter = '0;
                    c_d.step = 2'd0;
                end
            end
            S_RST: c_d.st = S_A1;
            S_A1: begin
                c_d.a1 = draw_addr;
                c_d.st = S_A2;
            end
            S_A2: begin
                if (draw_addr != c_q.a1) begin
                    c_d.a2 = draw_addr;
                    c_d.st = S_L1;
                end
            end
            S_L1: begin
                c_d.l1 = draw & LEFT_MASK;
                c_d.st = S_R1;
            end
            S_R1: begin
                c_d.r1 = draw;
                c_d.st = S_L2;
            end
            S_L2: begin
                c_d.l2 = draw & LEFT_MASK;
                c_d.st = S_R2;
            end
            S_R2: begin
                c_d.r2   = draw;
                c_d.step = 2'd0;
                c_d.st   = S_WR;
            end
            S_WR: begin
                c_d.step = c_q.step + 2'd1;
                if (c_q.step == 2'd3) c_d.st = S_RD;
            end
            S_RD: c_d.st = S_CK;
            S_CK: begin
                if (mismatch) begin
                    c_d.fail = 1'b1;
                    c_d.code = c_q.step;
                    c_d.st   = S_DONE;
                end else if (c_q.step == 2'd3) begin
                    c_d.step = 2'd0;
                    if (c_q.iter == LAST_ITER) begin
                        c_d.st = S_DONE;
                    end else begin
                        c_d.iter = c_q.iter + ITER_W'(1);
                        c_d.st   = S_A1;
                    end
                end else begin
                    c_d.step = c_q.step + 2'd1;
                    c_d.st   = S_RD;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= S_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign done      = (c_q.st == S_DONE);
    assign fail      = c_q.fail;
    assign fail_code = c_q.code;
    assign uut_rst   = (c_q.st == S_RST);
    assign mem_en    = (c_q.st == S_WR) || (c_q.st == S_RD);
    assign mem_we    = (c_q.st == S_WR);
    assign mem_half  = op_half;
    assign mem_addr  = op_addr;
    assign mem_wdata = op_data;

    // R3
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uut_rst |=> (!uut_rst && !mem_en));

    // R6
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !mem_en);

    // R7
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R8
    access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_code)));

    // R10
    distinct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (c_q.a1 != c_q.a2));

endmodule

// File: tb/pairmem_tester_tb.sv
module pairmem_tester_tb_top;

    localparam int              AW   = 4;
    localparam int              DW   = 16;
    localparam int              IT   = 5;
    localparam logic [DW-1:0]   LM   = 16'h0FFF;
    localparam logic [DW-1:0]   TAPS = 16'hB400;
    localparam int              MAXN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic seed_load = 1'b0;
    logic [DW-1:0] seed_in = '0;
    logic busy, done, fail, uut_rst, mem_en, mem_we, mem_half;
    logic [1:0] fail_code;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #5 clk = ~clk;

    pairmem_tester #(
        .ADDR_W(AW), .DATA_W(DW), .ITERATIONS(IT), .LEFT_MASK(LM), .LFSR_TAPS(TAPS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed_in(seed_in),
        .busy(busy), .done(done), .fail(fail), .fail_code(fail_code), .uut_rst(uut_rst),
        .mem_en(mem_en), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model with read fault injection
    logic [DW-1:0] mem_l [16];
    logic [DW-1:0] mem_r [16];
    int  rd_seen = 0;
    int  corrupt_idx = -1;
    bit  fill_upper = 1'b0;

    always @(posedge clk) begin
        logic [DW-1:0] v;
        if (uut_rst) rd_seen <= 0;
        if (mem_en) begin
            if (mem_we) begin
                if (mem_half) mem_r[mem_addr] <= mem_wdata;
                else          mem_l[mem_addr] <= mem_wdata;
            end else begin
                v = mem_half ? mem_r[mem_addr] : mem_l[mem_addr];
                if (!mem_half && fill_upper) v = v | ~LM;
                if (rd_seen == corrupt_idx) v = v ^ 16'h0001;
                mem_rdata <= v;
                rd_seen   <= rd_seen + 1;
            end
        end
    end

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model
    logic [DW-1:0] ms;
    logic [AW-1:0] e_addr [MAXN];
    logic          e_half [MAXN];
    logic [DW-1:0] e_data [MAXN];
    int ne;

    function automatic logic [DW-1:0] nx(input logic [DW-1:0] s);
        return (s >> 1) ^ (s[0] ? TAPS : '0);
    endfunction

    task automatic gen(input int iters);
        logic [AW-1:0] a1, a2;
        logic [DW-1:0] l1, r1, l2, r2;
        ne = 0;
        for (int i = 0; i < iters; i++) begin
            a1 = ms[AW-1:0]; ms = nx(ms);
            a2 = ms[AW-1:0]; ms = nx(ms);
            while (a2 == a1) begin a2 = ms[AW-1:0]; ms = nx(ms); end
            l1 = ms & LM; ms = nx(ms);
            r1 = ms;      ms = nx(ms);
            l2 = ms & LM; ms = nx(ms);
            r2 = ms;      ms = nx(ms);
            e_addr[ne] = a1; e_half[ne] = 0; e_data[ne] = l1; ne++;
            e_addr[ne] = a1; e_half[ne] = 1; e_data[ne] = r1; ne++;
            e_addr[ne] = a2; e_half[ne] = 0; e_data[ne] = l2; ne++;
            e_addr[ne] = a2; e_half[ne] = 1; e_data[ne] = r2; ne++;
        end
    endtask

    // run log
    logic [AW-1:0] w_addr [MAXN];
    logic          w_half [MAXN];
    logic [DW-1:0] w_data [MAXN];
    logic [AW-1:0] r_addr [MAXN];
    logic          r_half [MAXN];
    int nw, nr, nrst, rst_cyc, first_acc;

    task automatic load_seed(input logic [DW-1:0] s);
        @(negedge clk); seed_load = 1'b1; seed_in = s;
        @(negedge clk); seed_load = 1'b0;
    endtask

    task automatic run(input int load_at, input logic [DW-1:0] busy_seed);
        int cyc;
        nw = 0; nr = 0; nrst = 0; rst_cyc = -1; first_acc = -1; cyc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && cyc < 5000) begin
            if (uut_rst) begin nrst++; rst_cyc = cyc; end
            if (mem_en) begin
                if (first_acc < 0) first_acc = cyc;
                if (mem_we && nw < MAXN) begin
                    w_addr[nw] = mem_addr; w_half[nw] = mem_half; w_data[nw] = mem_wdata; nw++;
                end else if (!mem_we && nr < MAXN) begin
                    r_addr[nr] = mem_addr; r_half[nr] = mem_half; nr++;
                end
            end
            if (cyc == load_at) begin seed_load = 1'b1; seed_in = busy_seed; end
            else seed_load = 1'b0;
            @(negedge clk);
            cyc++;
        end
        seed_load = 1'b0;
        check(done, "R8", "run finished", done, 1);
    endtask

    task automatic check_streams(input string req);
        int bad_w, bad_r;
        bad_w = -1; bad_r = -1;
        for (int k = 0; k < nw && k < ne; k++)
            if (bad_w < 0 && (w_addr[k] != e_addr[k] || w_half[k] != e_half[k] || w_data[k] != e_data[k]))
                bad_w = k;
        for (int k = 0; k < nr && k < ne; k++)
            if (bad_r < 0 && (r_addr[k] != e_addr[k] || r_half[k] != e_half[k]))
                bad_r = k;
        // R4 R5: write address/half/data stream
        check(bad_w < 0, req, "write stream first bad index", bad_w, -1);
        if (bad_w >= 0)
            check(0, req, "write data at bad index", w_data[bad_w], e_data[bad_w]);
        // R6: read order mirrors write order
        check(bad_r < 0, "R6", "read stream first bad index", bad_r, -1);
    endtask

    task automatic check_pass(input string req);
        check(!fail, req, "fail flag", fail, 0);
        check(nw == 4 * IT, "R8", "write count", nw, 4 * IT);
        check(nr == 4 * IT, "R8", "read count", nr, 4 * IT);
        check_streams(req);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        // R1
        check(!done && !busy && !fail, "R1", "status after reset", {done, busy, fail}, 0);
        check(!mem_en && !uut_rst, "R1", "no access after reset", {mem_en, uut_rst}, 0);
    endtask

    task automatic t_pass_basic;
        bit distinct;
        load_seed(16'h1234); ms = 16'h1234; gen(IT);
        run(-1, '0);
        check_pass("R4");
        check_pass("R5");
        // R3
        check(nrst == 1, "R3", "uut_rst pulse count", nrst, 1);
        check(rst_cyc >= 0 && rst_cyc < first_acc, "R3", "uut_rst before first access", rst_cyc, first_acc);
        // R10
        distinct = 1'b1;
        for (int i = 0; i < IT; i++) if (w_addr[4*i] == w_addr[4*i+2]) distinct = 1'b0;
        check(distinct, "R10", "pair addresses distinct", distinct, 1);
    endtask

    task automatic t_zero_seed;
        load_seed(16'h0000); ms = 16'h0001; gen(IT);
        run(-1, '0);
        check_pass("R2");
    endtask

    task automatic t_mask;
        fill_upper = 1'b1;
        load_seed(16'hBEEF); ms = 16'hBEEF; gen(IT);
        run(-1, '0);
        // R6: junk outside LEFT_MASK on left reads must not fail the run
        check_pass("R6");
        fill_upper = 1'b0;
    endtask

    task automatic t_fail(input int idx);
        int iters;
        iters = idx / 4 + 1;
        corrupt_idx = idx;
        load_seed(16'h5A5A); ms = 16'h5A5A; gen(iters);
        run(-1, '0);
        // R7
        check(fail, "R7", "fail flag", fail, 1);
        check(fail_code == 2'(idx % 4), "R7", "fail_code", fail_code, idx % 4);
        check(nr == idx + 1, "R7", "reads before stop", nr, idx + 1);
        check(nw == 4 * iters, "R7", "writes before stop", nw, 4 * iters);
        corrupt_idx = -1;
    endtask

    task automatic t_hold_restart;
        load_seed(16'h0F0F); ms = 16'h0F0F; gen(IT);
        run(-1, '0);
        check_pass("R9");
        repeat (10) @(negedge clk);
        // R9: held status while idle
        check(done && !fail && !busy, "R9", "held status", {done, fail, busy}, 3'b100);
        gen(IT);
        run(-1, '0);
        check_pass("R9");
    endtask

    task automatic t_load_busy;
        load_seed(16'hC3A5); ms = 16'hC3A5; gen(IT);
        run(7, 16'h1111);
        // R2: seed load during the run is ignored
        check_pass("R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass_basic();
        t_zero_seed();
        t_mask();
        for (int k = 0; k < 4; k++) t_fail(k);
        t_fail(5);
        t_hold_restart();
        t_load_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule